// File: doc/BRIEF.md
# Remote DMA Data Port

This block gives a host processor byte-stream access to a network controller's local storage through one data-port location. The host first loads a 16-bit remote pointer and a 16-bit remaining-byte count. Each later access to the data port then reads or writes local storage at the pointer, moves the pointer forward by the size of the access, and lowers the count. When the count runs out, the block raises a one-cycle completion pulse.

Local storage has two windows. A small identification store sits at the bottom of the address space and is filled at reset from the station address. The packet buffer sits higher up and is built from four byte-wide banks, so an access of up to four bytes writes each bank at most once. The pointer follows the receive ring. When it lands exactly on the ring's end page, it goes back to the ring's first page.

A data access is 8 bits wide. It is 16 bits wide when the word-mode configuration input is set, and 32 bits wide when the host marks it as a wide access. Register decoding is outside this block. Ring pages, the pointer and count loads, and the word-mode bit arrive as plain inputs.

Top module: `rdma_port`

## Requirements
- R1: After reset the pointer is 0x0000, the count is 0, and `dma_done` and `rvalid` are 0. The identification store holds 16 source bytes, each copied to addresses 2k and 2k+1. Source byte k for k<6 is `station_addr[8k+7:8k]`. Source bytes 14 and 15 are 0x57. All other source bytes are 0x00.
- R2: The access size is 4 bytes when `req_wide`=1. Otherwise it is 2 bytes when `cfg_word16`=1 and 1 byte when it is 0. An accepted access adds the size to the pointer.
- R3: After an accepted access, a pointer that equals exactly `{ring_stop_pg,8'h00}` is replaced by `{ring_start_pg,8'h00}`.
- R4: If the count is less than or equal to the access size, the count becomes 0 and `dma_done` pulses high in the cycle after the access. Otherwise the count drops by the access size and `dma_done` stays low.
- R5: A write request while the count is 0 changes nothing: not storage, pointer, count or `dma_done`. Read requests at count 0 proceed and pulse `dma_done`.
- R6: The block reads as all ones in the low 8, 16 or 32 bits, with zeros above, when the access does not lie wholly below address 32 or wholly inside the packet buffer window. Writes to such an access are dropped. The pointer and count still advance.
- R7: For 2- and 4-byte accesses, bit 0 of the pointer is treated as 0 when forming the storage address. Byte j of `wdata` and `rdata` (bits 8j+7:8j) maps to storage address base+j.
- R8: An access that crosses the ring end is carried out wholly at its unwrapped addresses. The pointer wraps only if the advanced value equals the end exactly.
- R9: Read data appears on `rdata`, with `rvalid`=1 for one cycle, in the cycle after the read request. `rdata` holds its value until the next read.
- R10: A cycle with `ld_addr` or `ld_cnt` set loads the given values. Any data request in that same cycle is discarded.
- R11: A 4-byte access is in a window only if all four of its bytes are. For example, a 4-byte read at 0x1E returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| station_addr | input | 48 | Station address copied into the identification store at reset, byte 0 in bits 7:0 |
| cfg_word16 | input | 1 | 1 selects 2-byte data accesses |
| ring_start_pg | input | PAGE_W (8) | First page of the ring |
| ring_stop_pg | input | PAGE_W (8) | Page one past the ring end |
| ld_addr | input | 1 | Load the pointer |
| ld_addr_val | input | ADDR_W (16) | Pointer load value |
| ld_cnt | input | 1 | Load the count |
| ld_cnt_val | input | CNT_W (16) | Count load value |
| req | input | 1 | Data-port access this cycle |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | 1 for a 4-byte access |
| wdata | input | 32 | Write data, little-endian |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | Read data valid pulse |
| cur_addr | output | ADDR_W (16) | Current pointer |
| cur_cnt | output | CNT_W (16) | Remaining count |
| dma_done | output | 1 | Count-exhausted pulse |

## Verification
The bench builds the block with its defaults. The packet buffer is 1 KiB at 0x4000, so the window ends at 0x4400, and the identification store is 32 bytes. With these sizes, the ring end can be moved onto page 0x42 inside the buffer. That brings exact wraps, bank-crossing wide accesses past the end, and reads just beyond both windows within a few dozen cycles. Writing a handful of bytes and then reading them back at other widths and alignments exercises every bank rotation.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [1:0] {XF_BYTE = 2'd0, XF_HALF = 2'd1, XF_WORD = 2'd2} xfer_e;

  function automatic logic [2:0] xfer_len(xfer_e xf);
    case (xf)
      XF_HALF: return 3'd2;
      XF_WORD: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/rdp_window.sv
module rdp_window #(
  parameter int ADDR_W     = 16,
  parameter int PROM_BYTES = 32,
  parameter int RAM_BASE   = 'h4000,
  parameter int RAM_BYTES  = 1024
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        len,
  output logic              in_prom,
  output logic              in_ram
);
  localparam logic [ADDR_W:0] PROM_END = (ADDR_W+1)'(PROM_BYTES);
  localparam logic [ADDR_W:0] RAM_LO   = (ADDR_W+1)'(RAM_BASE);
  localparam logic [ADDR_W:0] RAM_END  = (ADDR_W+1)'(RAM_BASE + RAM_BYTES);

  logic [ADDR_W:0] last_b;
  always_comb begin
    last_b  = {1'b0, base} + (ADDR_W+1)'(len) - 1'b1;
    in_prom = last_b < PROM_END;
    in_ram  = ({1'b0, base} >= RAM_LO) && (last_b < RAM_END);
  end
endmodule

// File: rtl/rdp_prom.sv
module rdp_prom #(
  parameter int         PROM_BYTES = 32,
  parameter int         MAC_BYTES  = 6,
  parameter logic [7:0] SIG        = 8'h57
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [8*MAC_BYTES-1:0]         mac,
  input  logic [3:0]                     we,
  input  logic [3:0][$clog2(PROM_BYTES)-1:0] idx,
  input  logic [3:0][7:0]                wd,
  input  logic                           re,
  output logic [3:0][7:0]                q
);
  localparam int SRC = PROM_BYTES / 2;
  logic [7:0] mem [PROM_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PROM_BYTES; i++) begin
        if (i / 2 < MAC_BYTES)       mem[i] <= mac[8*(i/2) +: 8];
        else if (i / 2 >= SRC - 2)   mem[i] <= SIG;
        else                         mem[i] <= 8'h00;
      end
    end else begin
      for (int j = 0; j < 4; j++)
        if (we[j]) mem[idx[j]] <= wd[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (re)
      for (int j = 0; j < 4; j++) q[j] <= mem[idx[j]];
  end
endmodule

// File: rtl/rdp_ram.sv
module rdp_ram #(
  parameter int RAM_BYTES = 1024,
  localparam int BANK_DEPTH = RAM_BYTES / 4,
  localparam int ROW_W = $clog2(BANK_DEPTH)
) (
  input  logic                  clk,
  input  logic [3:0]            we,
  input  logic [3:0][ROW_W-1:0] row,
  input  logic [3:0][7:0]       wd,
  input  logic                  re,
  output logic [3:0][7:0]       q
);
  for (genvar b = 0; b < 4; b++) begin : g_bank
    logic [7:0] mem [BANK_DEPTH];
    logic [7:0] q_b;
    always_ff @(posedge clk) begin
      if (we[b]) mem[row[b]] <= wd[b];
      if (re)    q_b <= mem[row[b]];
    end
    assign q[b] = q_b;
  end
endmodule

// File: rtl/rdp_ptr.sv
module rdp_ptr #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int PAGE_W = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [2:0]        len,
  input  logic              ld_addr,
  input  logic [ADDR_W-1:0] ld_addr_val,
  input  logic              ld_cnt,
  input  logic [CNT_W-1:0]  ld_cnt_val,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  output logic              go,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              done_q
);
  logic [ADDR_W-1:0] adv;
  logic              last;

  always_comb begin
    go   = req && !ld_addr && !ld_cnt && (!req_wr || cnt_q != '0);
    adv  = addr_q + ADDR_W'(len);
    last = cnt_q <= CNT_W'(len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= go && last;
      if (ld_addr) addr_q <= ld_addr_val;
      if (ld_cnt)  cnt_q  <= ld_cnt_val;
      if (go) begin
        addr_q <= (adv == {stop_pg, 8'h00}) ? {start_pg, 8'h00} : adv;
        cnt_q  <= last ? '0 : cnt_q - CNT_W'(len);
      end
    end
  end

  // R5: a write at zero count leaves pointer and count alone
  p_wr_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    req && req_wr && cnt_q == '0 && !ld_addr && !ld_cnt |=> addr_q == $past(addr_q) && cnt_q == '0 && !done_q);
  // R4: count steps down by the size when it does not run out
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    go && cnt_q > CNT_W'(len) |=> cnt_q == $past(cnt_q) - CNT_W'($past(len)) && !done_q);
  // R4: completion only with an empty count
  p_done_empty_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |-> cnt_q == '0);
  // R3: exact hit on the ring end returns to the start page
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    go && adv == {stop_pg, 8'h00} |=> addr_q == {$past(start_pg), 8'h00});
  // R10: loads take precedence over a data request
  p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
    ld_cnt |=> cnt_q == $past(ld_cnt_val) && !done_q);
endmodule

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int PROM_BYTES = 32,
  parameter int RAM_BASE   = 'h4000,
  parameter int RAM_BYTES  = 1024,
  localparam int PAGE_W    = ADDR_W - 8,
  localparam int PROM_IW   = $clog2(PROM_BYTES),
  localparam int ROW_W     = $clog2(RAM_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [47:0]       station_addr,
  input  logic              cfg_word16,
  input  logic [PAGE_W-1:0] ring_start_pg,
  input  logic [PAGE_W-1:0] ring_stop_pg,
  input  logic              ld_addr,
  input  logic [ADDR_W-1:0] ld_addr_val,
  input  logic              ld_cnt,
  input  logic [CNT_W-1:0]  ld_cnt_val,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_wide,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              dma_done
);
  import rdp_pkg::*;

  xfer_e             xf;
  logic [2:0]        len;
  logic [ADDR_W-1:0] base, off;
  logic              go, wr_go, rd_go, in_prom, in_ram;

  always_comb begin
    xf    = req_wide ? XF_WORD : (cfg_word16 ? XF_HALF : XF_BYTE);
    len   = xfer_len(xf);
    base  = (xf == XF_BYTE) ? cur_addr : {cur_addr[ADDR_W-1:1], 1'b0};
    off   = base - ADDR_W'(RAM_BASE);
    wr_go = go && req_wr;
    rd_go = go && !req_wr;
  end

  rdp_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
    .clk, .rst, .req, .req_wr, .len, .ld_addr, .ld_addr_val, .ld_cnt, .ld_cnt_val,
    .start_pg(ring_start_pg), .stop_pg(ring_stop_pg), .go,
    .addr_q(cur_addr), .cnt_q(cur_cnt), .done_q(dma_done)
  );

  rdp_window #(.ADDR_W(ADDR_W), .PROM_BYTES(PROM_BYTES), .RAM_BASE(RAM_BASE),
               .RAM_BYTES(RAM_BYTES)) u_win (
    .base, .len, .in_prom, .in_ram
  );

  // Lane j of the identification store takes byte j of the access.
  logic [3:0]              p_we;
  logic [3:0][PROM_IW-1:0] p_idx;
  logic [3:0][7:0]         p_wd, p_q;
  always_comb begin
    for (int j = 0; j < 4; j++) begin
      p_idx[j] = PROM_IW'(base + ADDR_W'(j));
      p_wd[j]  = wdata[8*j +: 8];
      p_we[j]  = wr_go && in_prom && (j < int'(len));
    end
  end

  rdp_prom #(.PROM_BYTES(PROM_BYTES)) u_prom (
    .clk, .rst, .mac(station_addr), .we(p_we), .idx(p_idx), .wd(p_wd), .re(rd_go), .q(p_q)
  );

  // Bank b of the packet buffer takes byte (b - off) mod 4 of the access.
  logic [3:0]            r_we;
  logic [3:0][ROW_W-1:0] r_row;
  logic [3:0][7:0]       r_wd, r_q;
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      logic [1:0] jb;
      jb       = 2'(b) - off[1:0];
      r_row[b] = ROW_W'((off + ADDR_W'(jb)) >> 2);
      r_wd[b]  = wdata[8*jb +: 8];
      r_we[b]  = wr_go && in_ram && ({1'b0, jb} < len);
    end
  end

  rdp_ram #(.RAM_BYTES(RAM_BYTES)) u_ram (
    .clk, .we(r_we), .row(r_row), .wd(r_wd), .re(rd_go), .q(r_q)
  );

  // Read-side selection registered with the access.
  logic       sel_prom_q, sel_ram_q;
  logic [1:0] rot_q;
  logic [2:0] len_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid     <= 1'b0;
      sel_prom_q <= 1'b0;
      sel_ram_q  <= 1'b0;
      rot_q      <= '0;
      len_q      <= 3'd1;
    end else begin
      rvalid <= rd_go;
      if (rd_go) begin
        sel_prom_q <= in_prom;
        sel_ram_q  <= in_ram;
        rot_q      <= off[1:0];
        len_q      <= len;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      if (j >= int'(len_q))  rdata[8*j +: 8] = 8'h00;
      else if (sel_ram_q)    rdata[8*j +: 8] = r_q[2'(rot_q + 2'(j))];
      else if (sel_prom_q)   rdata[8*j +: 8] = p_q[j];
      else                   rdata[8*j +: 8] = 8'hFF;
    end
  end

  // R9: read data valid strictly follows an accepted read
  p_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(req && !req_wr && !ld_addr && !ld_cnt));
  // R6: a read outside both windows returns ones for its width
  p_ones_r6: assert property (@(posedge clk) disable iff (rst)
    rd_go && !in_prom && !in_ram && xf == XF_BYTE |=> rdata == 32'h0000_00FF);
  // R2: a byte access moves an unloaded pointer by one unless it wraps
  p_step_byte_r2: assert property (@(posedge clk) disable iff (rst)
    go && xf == XF_BYTE && (cur_addr + 1'b1) != {ring_stop_pg, 8'h00} |=> cur_addr == $past(cur_addr) + 1'b1);
endmodule

// File: tb/tb_rdma_port.sv
module tb_rdma_port;
  logic        clk = 1'b0;
  logic        rst;
  logic [47:0] station_addr = 48'h6655_4433_2211;
  logic        cfg_word16, ld_addr, ld_cnt, req, req_wr, req_wide;
  logic [7:0]  ring_start_pg, ring_stop_pg;
  logic [15:0] ld_addr_val, ld_cnt_val, cur_addr, cur_cnt;
  logic [31:0] wdata, rdata;
  logic        rvalid, dma_done;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  rdma_port dut (.*);

  typedef struct packed {
    logic [1:0]  kind;   // 0 load pointer, 1 load count, 2 write, 3 read
    logic        wide;
    logic        c16;
    logic [31:0] data;
    logic [31:0] e_rd;
    logic [15:0] e_addr;
    logic [15:0] e_cnt;
    logic        e_done;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VT [NV] = '{
    '{2'd0,1'b0,1'b0,32'h4000,32'h0,16'h4000,16'h0,1'b0,4'd10},       // R10 load
    '{2'd1,1'b0,1'b0,32'h0008,32'h0,16'h4000,16'h8,1'b0,4'd10},
    '{2'd2,1'b0,1'b0,32'h00AB,32'h0,16'h4001,16'h7,1'b0,4'd2},        // R2 byte step
    '{2'd2,1'b0,1'b1,32'h1234,32'h0,16'h4003,16'h5,1'b0,4'd2},        // R2 half step
    '{2'd2,1'b1,1'b0,32'hDEADBEEF,32'h0,16'h4007,16'h1,1'b0,4'd2},    // R2 word step
    '{2'd2,1'b0,1'b1,32'h5555,32'h0,16'h4009,16'h0,1'b1,4'd4},        // R4 saturate
    '{2'd0,1'b0,1'b0,32'h4006,32'h0,16'h4006,16'h0,1'b0,4'd10},
    '{2'd2,1'b0,1'b0,32'h0077,32'h0,16'h4006,16'h0,1'b0,4'd5},        // R5 ignored
    '{2'd0,1'b0,1'b0,32'h4000,32'h0,16'h4000,16'h0,1'b0,4'd10},
    '{2'd3,1'b1,1'b0,32'h0,32'hBEEF1234,16'h4004,16'h0,1'b1,4'd7},    // R7 little-endian
    '{2'd3,1'b0,1'b1,32'h0,32'h0000DEAD,16'h4006,16'h0,1'b1,4'd9},    // R9
    '{2'd3,1'b0,1'b0,32'h0,32'h00000055,16'h4007,16'h0,1'b1,4'd5},    // R5 store kept
    '{2'd0,1'b0,1'b0,32'h4001,32'h0,16'h4001,16'h0,1'b0,4'd10},
    '{2'd3,1'b0,1'b1,32'h0,32'h00001234,16'h4003,16'h0,1'b1,4'd7},    // R7 odd pointer
    '{2'd0,1'b0,1'b0,32'h0000,32'h0,16'h0000,16'h0,1'b0,4'd10},
    '{2'd3,1'b0,1'b1,32'h0,32'h00001111,16'h0002,16'h0,1'b1,4'd1},    // R1 pair
    '{2'd0,1'b0,1'b0,32'h000A,32'h0,16'h000A,16'h0,1'b0,4'd10},
    '{2'd3,1'b0,1'b1,32'h0,32'h00006666,16'h000C,16'h0,1'b1,4'd1},
    '{2'd3,1'b0,1'b0,32'h0,32'h00000000,16'h000D,16'h0,1'b1,4'd1},
    '{2'd0,1'b0,1'b0,32'h001C,32'h0,16'h001C,16'h0,1'b0,4'd10},
    '{2'd3,1'b1,1'b0,32'h0,32'h57575757,16'h0020,16'h0,1'b1,4'd1},
    '{2'd3,1'b0,1'b0,32'h0,32'h000000FF,16'h0021,16'h0,1'b1,4'd6},    // R6 byte
    '{2'd3,1'b0,1'b1,32'h0,32'h0000FFFF,16'h0023,16'h0,1'b1,4'd6},    // R6 half
    '{2'd3,1'b1,1'b0,32'h0,32'hFFFFFFFF,16'h0027,16'h0,1'b1,4'd6},    // R6 word
    '{2'd0,1'b0,1'b0,32'h001E,32'h0,16'h001E,16'h0,1'b0,4'd10},
    '{2'd3,1'b1,1'b0,32'h0,32'hFFFFFFFF,16'h0022,16'h0,1'b1,4'd11}    // R11 partial
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ld_addr = 0; ld_cnt = 0; req = 0; req_wr = 0; req_wide = 0; wdata = '0;
  endtask

  task automatic op(input logic [1:0] kind, input logic wide, input logic c16, input logic [31:0] d);
    @(negedge clk);
    cfg_word16 = c16; req_wide = wide; wdata = d;
    case (kind)
      2'd0: begin ld_addr = 1; ld_addr_val = d[15:0]; end
      2'd1: begin ld_cnt = 1; ld_cnt_val = d[15:0]; end
      2'd2: begin req = 1; req_wr = 1; end
      default: begin req = 1; req_wr = 0; end
    endcase
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    cfg_word16 = 0; ld_addr_val = '0; ld_cnt_val = '0;
    ring_start_pg = 8'h40; ring_stop_pg = 8'h44;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    chk("R1 addr", 32'(cur_addr), 32'h0);
    chk("R1 cnt", 32'(cur_cnt), 32'h0);
    chk("R1 done/rvalid", {30'h0, dma_done, rvalid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string t;
      op(VT[i].kind, VT[i].wide, VT[i].c16, VT[i].data);
      t = $sformatf("R%0d vec%0d", VT[i].rq, i);
      chk({t, " addr"}, 32'(cur_addr), 32'(VT[i].e_addr));
      chk({t, " cnt"}, 32'(cur_cnt), 32'(VT[i].e_cnt));
      chk({t, " done"}, 32'(dma_done), 32'(VT[i].e_done));
      chk({t, " rvalid"}, 32'(rvalid), 32'(VT[i].kind == 2'd3));
      if (VT[i].kind == 2'd3) chk({t, " rdata"}, rdata, VT[i].e_rd);
    end

    // R3 exact wrap with ring end moved to page 0x42
    ring_stop_pg = 8'h42;
    op(2'd0, 0, 0, 32'h41FE);
    op(2'd1, 0, 0, 32'h0020);
    op(2'd2, 0, 1, 32'hCAFE);
    chk("R3 wrap addr", 32'(cur_addr), 32'h4000);
    chk("R3 wrap cnt", 32'(cur_cnt), 32'h1E);
    // R8 wide write across the end, no exact hit
    op(2'd0, 0, 0, 32'h41FE);
    op(2'd2, 1, 0, 32'h44332211);
    chk("R8 no wrap addr", 32'(cur_addr), 32'h4202);
    chk("R8 cnt", 32'(cur_cnt), 32'h1A);
    op(2'd0, 0, 0, 32'h4200);
    op(2'd3, 0, 0, 32'h0);
    chk("R8 byte past end", rdata, 32'h33);
    chk("R8 addr", 32'(cur_addr), 32'h4201);
    // R10 load and request in the same cycle
    @(negedge clk);
    ld_cnt = 1; ld_cnt_val = 16'h0003; req = 1; req_wr = 1; cfg_word16 = 0; wdata = 32'hEE;
    @(negedge clk);
    idle();
    chk("R10 cnt", 32'(cur_cnt), 32'h3);
    chk("R10 addr", 32'(cur_addr), 32'h4201);
    chk("R10 done", 32'(dma_done), 32'h0);
    // R6 write outside windows still advances; R4 run-out by a larger step
    op(2'd0, 0, 0, 32'h3000);
    op(2'd2, 0, 1, 32'h9999);
    chk("R6 addr", 32'(cur_addr), 32'h3002);
    chk("R6 cnt", 32'(cur_cnt), 32'h1);
    op(2'd2, 0, 1, 32'h9999);
    chk("R4 cnt", 32'(cur_cnt), 32'h0);
    chk("R4 done", 32'(dma_done), 32'h1);
    @(negedge clk);
    chk("R4 done one cycle", 32'(dma_done), 32'h0);
    chk("R9 rdata held", rdata, 32'h33);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule